// File: doc/BRIEF.md
# Speculative Memory Dependence Checker

This unit sits on the memory side of a speculative loop-parallel system. Several compute nodes run iterations of one loop in parallel; a group of iterations that runs together is a chunk. Each node sends loads and stores to the unit. Every request carries the iteration number of its sender as a timestamp. The unit keeps the data, and for every location touched in the chunk it keeps a small tracking entry with the latest reader and writer timestamps. From these it detects when the parallel order broke the sequential order, and it raises a sticky violation flag.

Two undo logs hold the value that each location had before it was first touched: one for ordinary accesses and one for permanently cached reads. A permanently cached read pins its location with an infinite reader timestamp. That pin survives chunk commits, so any later store to the location is caught. A controller outside the unit issues commit or rollback at the end of a chunk. Each command walks the tracking table one entry per cycle and ends with a done pulse. Rollback replays the permanent log first and the normal log second, then empties every table.

The upper half of the address space (address MSB set) is the coarse segment. It is tracked per aligned 8-word line, and loads in it return the whole line. The lower half is tracked per word. The tracking table is direct-indexed. When two different locations map to the same slot, the unit flags a violation so that the controller rolls the chunk back.

Top module: `spec_dep_unit`

## Requirements
- R1: A load or permanent load that is accepted on the request port is answered one cycle later, with rsp_valid, the requester's rsp_id and rsp_line equal to the address MSB. In the fine segment the word sits in rsp_data[15:0] and all higher bits are zero. In the coarse segment word k of the aligned 8-word line sits in rsp_data[16k+15:16k]. A store produces no reply. Opcodes are 0 load, 1 permanent load, 2 store.
- R2: A store that raises no violation writes req_wdata to its word, and later loads return that word. A store that raises a violation leaves the data unchanged.
- R3: A load whose timestamp is lower than the last writer timestamp of its tracked location raises the violation flag. So does a store whose timestamp is lower than the last reader or last writer timestamp of its location.
- R4: Once raised, the violation flag stays set until a commit or rollback command is accepted, and that command clears it.
- R5: A permanent load gives its location an infinite reader timestamp (all ones; request timestamps stay below this). Any later store to that location raises a violation, even after one or more commits.
- R6: Rollback returns every location touched in the chunk to its value at the start of the chunk. When a location has entries in both logs, the normal-log value wins. Afterwards no tracking remains, permanent pins included.
- R7: Commit keeps all written data and drops all non-permanent tracking. After it, a store with any timestamp to a previously tracked, unpinned location raises no violation.
- R8: In the coarse segment, a store to one word and a load of another word of the same 8-word line are checked against each other. In the fine segment, neighbouring words are independent.
- R9: If a request maps to a table slot that already holds a different location (slot = low bits of the word address, or of the line number in the coarse segment), the violation flag is raised.
- R10: While a command walks the table, req_ready is low. A commit ends with a one-cycle cmd_done pulse TBL_N+1 cycles after the command cycle. A rollback ends 2*TBL_N+1 cycles after it. A command is accepted only while idle, and rollback wins over commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 2 | 0 load, 1 permanent load, 2 store |
| req_id | input | ID_W | Requester number |
| req_addr | input | ADDR_W | Word address; MSB selects coarse segment |
| req_ts | input | TS_W | Iteration timestamp |
| req_wdata | input | DATA_W | Store data |
| cmd_commit | input | 1 | Commit the chunk |
| cmd_rollback | input | 1 | Roll the chunk back |
| cmd_done | output | 1 | Pulse when a command finishes |
| violation | output | 1 | Sticky ordering violation flag |
| rsp_valid | output | 1 | Reply present |
| rsp_id | output | ID_W | Requester of the reply |
| rsp_line | output | 1 | Reply carries a full line |
| rsp_data | output | LINE_WORDS*DATA_W | Reply data |

## Verification
On every cycle, the assertions check how replies relate to accepted requests: when a reply appears, which requester it carries, the line flag, and the zeroed upper bits for fine-segment words. They also check that the violation flag holds until a command arrives, that a finished command leaves it clear, and that no reply appears during a table walk. Only the bench scenarios can show that timestamps order accesses correctly, that a pin survives commit, that a rollback restores values with the normal log winning, and that line-level tracking and slot collisions are detected. Each of these needs the data read back over several chunks.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_PLOAD = 2'd1,
        OP_STORE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_COMMIT  = 2'd1,
        M_RB_PERM = 2'd2,
        M_RB_NORM = 2'd3
    } mode_e;
endpackage

// File: rtl/sdu_locate.sv
// Maps a word address to its tracking key and table slot.
module sdu_locate #(
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              seg,
    output logic [ADDR_W-1:0] key,
    output logic [IDX_W-1:0]  idx
);
    localparam int LW_B = $clog2(LINE_WORDS);

    always_comb begin
        seg = addr[ADDR_W-1];
        if (seg) key = {1'b1, {LW_B{1'b0}}, addr[ADDR_W-2:LW_B]};
        else     key = addr;
        idx = key[IDX_W-1:0];
    end
endmodule

// File: rtl/sdu_check.sv
// Compares a request against the tracking entry held in its slot.
module sdu_check #(
    parameter int ADDR_W = 8,
    parameter int TS_W   = 8
) (
    input  logic              ent_vld,
    input  logic [ADDR_W-1:0] ent_key,
    input  logic              ent_rd_vld,
    input  logic [TS_W-1:0]   ent_rd_ts,
    input  logic              ent_wr_vld,
    input  logic [TS_W-1:0]   ent_wr_ts,
    input  logic [ADDR_W-1:0] key,
    input  logic              is_store,
    input  logic [TS_W-1:0]   ts,
    output logic              collide,
    output logic              dep_viol
);
    logic hit, late_wr, late_rd;

    always_comb begin
        hit      = ent_vld && (ent_key == key);
        collide  = ent_vld && !hit;
        late_wr  = ent_wr_vld && (ent_wr_ts > ts);
        late_rd  = ent_rd_vld && (ent_rd_ts > ts);
        dep_viol = hit && (late_wr || (is_store && late_rd));
    end
endmodule

// File: rtl/spec_dep_unit.sv
module spec_dep_unit
    import sdu_pkg::*;
#(
    parameter int ID_W       = 2,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int TS_W       = 8,
    parameter int TBL_N      = 16,
    parameter int LINE_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [ID_W-1:0]              req_id,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [TS_W-1:0]              req_ts,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic                         cmd_commit,
    input  logic                         cmd_rollback,
    output logic                         cmd_done,
    output logic                         violation,
    output logic                         rsp_valid,
    output logic [ID_W-1:0]              rsp_id,
    output logic                         rsp_line,
    output logic [LINE_WORDS*DATA_W-1:0] rsp_data
);
    localparam int MEM_N  = 1 << ADDR_W;
    localparam int IDX_W  = $clog2(TBL_N);
    localparam int LW_B   = $clog2(LINE_WORDS);
    localparam int LINE_W = LINE_WORDS * DATA_W;
    localparam logic [TS_W-1:0] TS_INF = {TS_W{1'b1}};

    typedef struct packed {
        logic              vld;
        logic              perm;
        logic [ADDR_W-1:0] key;
        logic              rd_vld;
        logic [TS_W-1:0]   rd_ts;
        logic              wr_vld;
        logic [TS_W-1:0]   wr_ts;
        logic              nlog_v;
        logic              plog_v;
    } ent_t;

    typedef struct packed {
        mode_e             mode;
        logic [IDX_W-1:0]  ptr;
        logic              viol;
        logic              done;
        logic              rsp_v;
        logic [ID_W-1:0]   rsp_id;
        logic              rsp_line;
        logic [LINE_W-1:0] rsp_data;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    ent_t              tbl_d [TBL_N];
    ent_t              tbl_q [TBL_N];
    logic [LINE_W-1:0] nlog_d [TBL_N];
    logic [LINE_W-1:0] nlog_q [TBL_N];
    logic [LINE_W-1:0] plog_d [TBL_N];
    logic [LINE_W-1:0] plog_q [TBL_N];
    logic [DATA_W-1:0] mem_d [MEM_N];
    logic [DATA_W-1:0] mem_q [MEM_N];

    logic              loc_seg;
    logic [ADDR_W-1:0] loc_key;
    logic [IDX_W-1:0]  loc_idx;
    ent_t              cur_ent, upd, rb;
    logic              collide, dep_viol, rb_do;
    logic [LINE_W-1:0] cur_line, rb_line;

    sdu_locate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS)) u_locate (
        .addr (req_addr),
        .seg  (loc_seg),
        .key  (loc_key),
        .idx  (loc_idx)
    );

    assign cur_ent = tbl_q[loc_idx];

    sdu_check #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_check (
        .ent_vld    (cur_ent.vld),
        .ent_key    (cur_ent.key),
        .ent_rd_vld (cur_ent.rd_vld),
        .ent_rd_ts  (cur_ent.rd_ts),
        .ent_wr_vld (cur_ent.wr_vld),
        .ent_wr_ts  (cur_ent.wr_ts),
        .key        (loc_key),
        .is_store   (req_op == OP_STORE),
        .ts         (req_ts),
        .collide    (collide),
        .dep_viol   (dep_viol)
    );

    // current value of the tracked unit: one word or an aligned line
    always_comb begin
        for (int k = 0; k < LINE_WORDS; k++) begin
            if (loc_seg)
                cur_line[k*DATA_W +: DATA_W] = mem_q[{req_addr[ADDR_W-1:LW_B], LW_B'(k)}];
            else if (k == 0)
                cur_line[k*DATA_W +: DATA_W] = mem_q[req_addr];
            else
                cur_line[k*DATA_W +: DATA_W] = '0;
        end
    end

    assign req_ready = (ctl_q.mode == M_IDLE) && !cmd_commit && !cmd_rollback;

    always_comb begin
        ctl_d       = ctl_q;
        tbl_d       = tbl_q;
        nlog_d      = nlog_q;
        plog_d      = plog_q;
        mem_d       = mem_q;
        ctl_d.done  = 1'b0;
        ctl_d.rsp_v = 1'b0;
        upd         = cur_ent;
        rb          = tbl_q[ctl_q.ptr];
        rb_line     = (ctl_q.mode == M_RB_PERM) ? plog_q[ctl_q.ptr] : nlog_q[ctl_q.ptr];
        rb_do       = ((ctl_q.mode == M_RB_PERM) && rb.plog_v) ||
                      ((ctl_q.mode == M_RB_NORM) && rb.nlog_v);

        // undo write-back shared by both rollback phases
        if (rb_do) begin
            if (rb.key[ADDR_W-1]) begin
                for (int k = 0; k < LINE_WORDS; k++)
                    mem_d[{1'b1, rb.key[ADDR_W-2-LW_B:0], LW_B'(k)}] = rb_line[k*DATA_W +: DATA_W];
            end else begin
                mem_d[rb.key] = rb_line[DATA_W-1:0];
            end
        end

        case (ctl_q.mode)
            M_IDLE: begin
                if (cmd_rollback) begin
                    ctl_d.mode = M_RB_PERM;
                    ctl_d.ptr  = '0;
                    ctl_d.viol = 1'b0;
                end else if (cmd_commit) begin
                    ctl_d.mode = M_COMMIT;
                    ctl_d.ptr  = '0;
                    ctl_d.viol = 1'b0;
                end else if (req_valid) begin
                    if (req_op != OP_STORE) begin
                        ctl_d.rsp_v    = 1'b1;
                        ctl_d.rsp_id   = req_id;
                        ctl_d.rsp_line = loc_seg;
                        ctl_d.rsp_data = cur_line;
                    end
                    if (collide || dep_viol) begin
                        ctl_d.viol = 1'b1;
                    end else begin
                        if (!upd.vld) begin
                            upd     = '0;
                            upd.vld = 1'b1;
                            upd.key = loc_key;
                        end
                        if (req_op != OP_PLOAD && !upd.nlog_v && !upd.perm) begin
                            nlog_d[loc_idx] = cur_line;
                            upd.nlog_v      = 1'b1;
                        end
                        case (req_op)
                            OP_PLOAD: begin
                                if (!upd.perm) begin
                                    plog_d[loc_idx] = cur_line;
                                    upd.plog_v      = 1'b1;
                                end
                                upd.perm   = 1'b1;
                                upd.rd_vld = 1'b1;
                                upd.rd_ts  = TS_INF;
                            end
                            OP_STORE: begin
                                if (!upd.wr_vld || upd.wr_ts < req_ts) upd.wr_ts = req_ts;
                                upd.wr_vld      = 1'b1;
                                mem_d[req_addr] = req_wdata;
                            end
                            default: begin
                                if (!upd.rd_vld || upd.rd_ts < req_ts) upd.rd_ts = req_ts;
                                upd.rd_vld = 1'b1;
                            end
                        endcase
                        tbl_d[loc_idx] = upd;
                    end
                end
            end
            M_COMMIT: begin
                if (rb.perm) tbl_d[ctl_q.ptr].nlog_v = 1'b0;
                else         tbl_d[ctl_q.ptr]        = '0;
                if (ctl_q.ptr == IDX_W'(TBL_N-1)) begin
                    ctl_d.mode = M_IDLE;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.ptr = ctl_q.ptr + IDX_W'(1);
                end
            end
            M_RB_PERM: begin
                if (ctl_q.ptr == IDX_W'(TBL_N-1)) begin
                    ctl_d.mode = M_RB_NORM;
                    ctl_d.ptr  = '0;
                end else begin
                    ctl_d.ptr = ctl_q.ptr + IDX_W'(1);
                end
            end
            default: begin
                tbl_d[ctl_q.ptr] = '0;
                if (ctl_q.ptr == IDX_W'(TBL_N-1)) begin
                    ctl_d.mode = M_IDLE;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.ptr = ctl_q.ptr + IDX_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            tbl_q  <= '{default: '0};
            nlog_q <= '{default: '0};
            plog_q <= '{default: '0};
            mem_q  <= '{default: '0};
        end else begin
            ctl_q  <= ctl_d;
            tbl_q  <= tbl_d;
            nlog_q <= nlog_d;
            plog_q <= plog_d;
            mem_q  <= mem_d;
        end
    end

    assign cmd_done  = ctl_q.done;
    assign violation = ctl_q.viol;
    assign rsp_valid = ctl_q.rsp_v;
    assign rsp_id    = ctl_q.rsp_id;
    assign rsp_line  = ctl_q.rsp_line;
    assign rsp_data  = ctl_q.rsp_data;
endmodule

// File: rtl/sdu_checker.sv
module sdu_checker
    import sdu_pkg::*;
#(
    parameter int ID_W   = 2,
    parameter int HI_W   = 112
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_op,
    input logic [ID_W-1:0] req_id,
    input logic            req_coarse,
    input logic            cmd_commit,
    input logic            cmd_rollback,
    input logic            cmd_done,
    input logic            violation,
    input logic            rsp_valid,
    input logic [ID_W-1:0] rsp_id,
    input logic            rsp_line,
    input logic [HI_W-1:0] rsp_hi
);
    // R1: accepted loads are answered next cycle with id and line flag
    a_r1_load_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op != OP_STORE) |=>
        (rsp_valid && rsp_id == $past(req_id) && rsp_line == $past(req_coarse)));

    // R1: stores get no reply
    a_r1_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == OP_STORE) |=> !rsp_valid);

    // R1: fine-segment reply carries zeros above the word
    a_r1_fine_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_line) |-> (rsp_hi == '0));

    // R4: flag holds until a command arrives
    a_r4_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !cmd_commit && !cmd_rollback) |=> violation);

    // R4: a finished command leaves the flag clear
    a_r4_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !violation);

    // R10: nothing is answered while the table is being walked
    a_r10_walk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !cmd_commit && !cmd_rollback) |=> !rsp_valid);
endmodule

bind spec_dep_unit sdu_checker #(
    .ID_W (ID_W),
    .HI_W (LINE_WORDS*DATA_W - DATA_W)
) u_sdu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_id       (req_id),
    .req_coarse   (req_addr[ADDR_W-1]),
    .cmd_commit   (cmd_commit),
    .cmd_rollback (cmd_rollback),
    .cmd_done     (cmd_done),
    .violation    (violation),
    .rsp_valid    (rsp_valid),
    .rsp_id       (rsp_id),
    .rsp_line     (rsp_line),
    .rsp_hi       (rsp_data[LINE_WORDS*DATA_W-1:DATA_W])
);

// File: tb/spec_dep_unit_test.sv
module spec_dep_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int TBL_N      = 16;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         req_valid = 0;
    logic         req_ready;
    logic [1:0]   req_op = 0;
    logic [1:0]   req_id = 0;
    logic [7:0]   req_addr = 0;
    logic [7:0]   req_ts = 0;
    logic [15:0]  req_wdata = 0;
    logic         cmd_commit = 0;
    logic         cmd_rollback = 0;
    logic         cmd_done;
    logic         violation;
    logic         rsp_valid;
    logic [1:0]   rsp_id;
    logic         rsp_line;
    logic [127:0] rsp_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [1:0]   id;
        logic         line;
        logic [127:0] data;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_dep_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_id(req_id), .req_addr(req_addr), .req_ts(req_ts),
        .req_wdata(req_wdata), .cmd_commit(cmd_commit), .cmd_rollback(cmd_rollback),
        .cmd_done(cmd_done), .violation(violation), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_line(rsp_line), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(0, "R1 unexpected reply", {126'd0, rsp_id}, 128'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_id == e.id && rsp_line == e.line && rsp_data == e.data,
                      e.tag, rsp_data, e.data);
            end
        end
    end

    // driver: one request, expected reply pushed for loads
    task automatic send(input logic [1:0] op, input logic [7:0] addr, input logic [7:0] ts,
                        input logic [15:0] wd, input logic [1:0] id,
                        input logic [127:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = addr; req_ts = ts; req_wdata = wd; req_id = id;
        if (op != 2'd2) begin
            exp_t e;
            e.id = id; e.line = addr[7]; e.data = exp; e.tag = tag;
            sb.push_back(e);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic run_cmd(input bit rb, input string tag);
        int n;
        @(negedge clk);
        if (rb) cmd_rollback = 1; else cmd_commit = 1;
        @(negedge clk);
        cmd_rollback = 0; cmd_commit = 0;
        n = 1;
        check(req_ready == 0, {tag, " R10 ready low in walk"}, {127'd0, req_ready}, 128'd0);
        while (!cmd_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(n == (rb ? 2*TBL_N+1 : TBL_N+1), {tag, " R10 walk length"}, 128'(n),
              128'(rb ? 2*TBL_N+1 : TBL_N+1));
        check(violation == 0, {tag, " R4 flag cleared"}, {127'd0, violation}, 128'd0);
    endtask

    task automatic viol_is(input logic exp, input string tag);
        check(violation == exp, tag, {127'd0, violation}, {127'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(violation == 0 && cmd_done == 0 && rsp_valid == 0 && req_ready == 1,
              "reset state", {124'd0, violation, cmd_done, rsp_valid, req_ready}, 128'h1);

        // R2: store then load returns data
        send(2, 8'h05, 1, 16'hAAAA, 1, 0, "");
        viol_is(0, "R2 clean store");
        send(0, 8'h05, 2, 0, 2, 128'hAAAA, "R2 load sees store");
        viol_is(0, "R2 clean load");

        // R3: load from earlier iteration after later write
        send(2, 8'h06, 3, 16'h3333, 0, 0, "");
        send(0, 8'h06, 1, 0, 0, 128'h3333, "R1 load reply");
        viol_is(1, "R3 load after later write");
        send(0, 8'h05, 2, 0, 3, 128'hAAAA, "R1 load reply id3");
        viol_is(1, "R4 flag sticky");

        // R6: rollback restores start values
        run_cmd(1, "rb1");
        send(0, 8'h05, 0, 0, 1, 128'h0, "R6 word 5 restored");
        send(0, 8'h06, 0, 0, 1, 128'h0, "R6 word 6 restored");
        run_cmd(0, "cm1");

        // R7: commit keeps data and drops tracking
        send(2, 8'h05, 4, 16'h1111, 0, 0, "");
        run_cmd(0, "cm2");
        send(2, 8'h05, 0, 16'h2222, 0, 0, "");
        viol_is(0, "R7 no stale violation after commit");
        send(0, 8'h05, 1, 0, 2, 128'h2222, "R2 load after new store");
        run_cmd(0, "cm3");

        // R3: store behind a later read, no write
        send(0, 8'h07, 3, 0, 1, 128'h0, "R1 fine load");
        send(2, 8'h07, 1, 16'h7777, 1, 0, "");
        viol_is(1, "R3 store after later read");
        send(0, 8'h07, 3, 0, 1, 128'h0, "R2 violating store not written");
        run_cmd(1, "rb2");

        // R5: pin survives commit
        send(1, 8'h09, 0, 0, 2, 128'h0, "R1 permanent load reply");
        viol_is(0, "R5 permanent load clean");
        run_cmd(0, "cm4");
        send(2, 8'h09, 5, 16'h9999, 2, 0, "");
        viol_is(1, "R5 store to pinned word");
        run_cmd(1, "rb3");
        send(0, 8'h09, 0, 0, 2, 128'h0, "R5 pinned word unchanged");
        send(2, 8'h09, 1, 16'h9191, 2, 0, "");
        viol_is(0, "R6 pin removed by rollback");
        run_cmd(0, "cm5");

        // R6: both logs, normal wins
        send(2, 8'h0A, 0, 16'h0A0A, 0, 0, "");
        run_cmd(0, "cm6");
        send(0, 8'h0A, 0, 0, 0, 128'h0A0A, "R6 first normal read");
        send(2, 8'h0A, 1, 16'hBBBB, 0, 0, "");
        send(1, 8'h0A, 2, 0, 0, 128'hBBBB, "R6 permanent read after store");
        viol_is(0, "R6 chunk clean before rollback");
        run_cmd(1, "rb4");
        send(0, 8'h0A, 0, 0, 0, 128'h0A0A, "R6 normal log wins");
        send(0, 8'h09, 0, 0, 0, 128'h9191, "R7 committed data kept");
        run_cmd(0, "cm7");

        // R9: slot collision
        send(0, 8'h03, 0, 0, 1, 128'h0, "R1 load slot 3");
        send(0, 8'h13, 0, 0, 1, 128'h0, "R1 load colliding word");
        viol_is(1, "R9 slot collision");
        run_cmd(1, "rb5");

        // R8: coarse line tracking
        send(2, 8'h80, 2, 16'h1234, 3, 0, "");
        viol_is(0, "R8 coarse store clean");
        send(0, 8'h85, 1, 0, 3, 128'h1234, "R1 coarse line reply");
        viol_is(1, "R8 same line conflict");
        run_cmd(1, "rb6");
        send(0, 8'h80, 0, 0, 3, 128'h0, "R6 coarse line restored");
        run_cmd(0, "cm8");
        send(2, 8'h20, 2, 16'h2020, 1, 0, "");
        send(0, 8'h21, 1, 0, 1, 128'h0, "R8 fine neighbour reply");
        viol_is(0, "R8 fine words independent");
        run_cmd(0, "cm9");
        send(2, 8'h8A, 0, 16'h00AA, 2, 0, "");
        send(0, 8'h88, 1, 0, 2, 128'h00AA << 32, "R1 line word placement");
        viol_is(0, "R8 earlier store later load clean");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1 all replies seen", 128'(sb.size()), 128'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule